// File: doc/BRIEF.md
# DMA Coherence Snoop Generator

This block sits on the path from a DMA port to an on-chip second-level SRAM. It keeps the first-level data and instruction caches coherent with DMA traffic. Before any word of a DMA burst reaches the SRAM, the block sends a command for each 64-byte line that the burst touches. The data cache gets one command per line. The instruction cache gets one per line on writes only. The block waits for each cache to acknowledge before it moves data for that line.

A dirty data-cache line is returned with the acknowledgement. On a DMA write, the block merges that line with the DMA words in a line buffer and then commits the whole line. On a DMA read, it first writes the returned line into the SRAM and then reads. A configuration bit selects whether a read snoop leaves the data-cache line valid or invalidates it.

Bursts that overlap the address window configured as second-level cache are refused. The same applies to bursts of length zero and bursts that run past the top of the address space. A refused burst gets an error response and causes no cache or SRAM traffic. The caches and the SRAM are external.

The controller has seven states:
- IDLE accepts a request. It moves to REJECT for a refused burst and to SNOOP otherwise.
- REJECT gives the error response and returns to IDLE.
- SNOOP holds the cache commands until both are acknowledged. It then moves to WBACK for a dirty line on a read, and to XFER in all other cases.
- WBACK writes the returned line to SRAM and then moves to XFER.
- XFER moves one word per cycle until the end of the line or of the burst. At that point it moves to MERGE for a dirty line on a write, to SNOOP for the next line, or to DONE.
- MERGE commits the buffered line and then moves to SNOOP or DONE.
- DONE gives the success response and returns to IDLE.

Top module: `coh_dma_snoop`

## Requirements
- R1: A burst is refused when any of the following holds:
  - its length is 0;
  - its last byte address (start + 4*length - 1) exceeds 0xFFFF;
  - its byte range overlaps the window [cfg_l2c_base, cfg_l2c_last].

  A refused burst gets dma_rsp_valid=1 with dma_rsp_err=1 in the cycle after acceptance. It causes no snoop, no instruction-cache invalidate, no SRAM access and no dma_wready.
- R2: A DMA write issues, for every line it touches, a data-cache snoop with dc_snp_inv=1 and an instruction-cache invalidate for the same line.
- R3: A DMA read issues a data-cache snoop for every line it touches, with dc_snp_inv equal to cfg_rd_inval sampled at acceptance. It issues no instruction-cache invalidate.
- R4: The line number is byte address bits [15:6]. A burst generates exactly one snoop per touched line, in ascending line order. A snoop stays asserted with a stable line number until it is acknowledged.
- R5: No dma_wready and no SRAM access occur while a snoop or invalidate for the current line is still unacknowledged.
- R6: On a DMA write to a line that the data cache reports dirty, the SRAM line afterwards holds the DMA words where the burst covers it. Every other word of the line holds the written-back data. Word i of the line is bits [32i+31:32i] of dc_snp_wb_data.
- R7: On a DMA read of a line that the data cache reports dirty, the read returns the written-back data, and the SRAM holds that data afterwards.
- R8: A DMA write to a clean line changes only the words the burst covers.
- R9: Read data appears on dma_rdata with dma_rvalid=1 once per word, in ascending address order. Write data is taken from dma_wdata in each cycle in which dma_wready=1, in ascending address order.
- R10: A completed burst ends with exactly one cycle of dma_rsp_valid=1 and dma_rsp_err=0.
- R11: After reset, dma_req_ready=1 and dc_snp_valid, ic_inv_valid, sram_en and dma_rsp_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_l2c_base | input | 16 | First byte address of the cache-mapped window |
| cfg_l2c_last | input | 16 | Last byte address of the cache-mapped window |
| cfg_rd_inval | input | 1 | 1: read snoops invalidate the data-cache line |
| dma_req_valid | input | 1 | Burst request |
| dma_req_ready | output | 1 | Request accepted when high with valid |
| dma_req_write | input | 1 | 1 write, 0 read |
| dma_req_addr | input | 16 | Start byte address (word aligned) |
| dma_req_len | input | 6 | Length in 32-bit words |
| dma_wready | output | 1 | Write word taken this cycle |
| dma_wdata | input | 32 | Write word |
| dma_rvalid | output | 1 | Read word valid |
| dma_rdata | output | 32 | Read word |
| dma_rsp_valid | output | 1 | Burst response pulse |
| dma_rsp_err | output | 1 | Response is a refusal |
| dc_snp_valid | output | 1 | Data-cache snoop request |
| dc_snp_inv | output | 1 | Snoop also invalidates |
| dc_snp_line | output | 10 | Line number of snoop |
| dc_snp_ack | input | 1 | Snoop done |
| dc_snp_dirty | input | 1 | Line was dirty, data attached |
| dc_snp_wb_data | input | 512 | Written-back line |
| ic_inv_valid | output | 1 | Instruction-cache invalidate |
| ic_inv_line | output | 10 | Line number to invalidate |
| ic_inv_ack | input | 1 | Invalidate done |
| sram_en | output | 1 | SRAM access |
| sram_we | output | 1 | SRAM write |
| sram_addr | output | 14 | SRAM word address |
| sram_wdata | output | 32 | SRAM write data |
| sram_rdata | input | 32 | SRAM read data, one cycle after a read |

## Verification
Directed bursts cover the following cases:
- a write to a clean line, which separates a plain store (R8) from a merge;
- a write into part of a dirty line, where only the merge gives the expected line (R6);
- reads of a dirty line with the invalidate policy off and on, which distinguish keep-valid from invalidate and show the write-back ordering (R7);
- a burst over three lines, which exposes a missing, repeated or out-of-order snoop;
- bursts just inside, across and beyond the cache window, and a zero-length burst, which tell acceptance from refusal.

Random bursts of random direction, length and policy run over lines that are randomly made dirty. A reference memory and a cache model kept by the bench give the expected data, snoop lists and cache states.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REJECT,
        ST_SNOOP,
        ST_WBACK,
        ST_XFER,
        ST_MERGE,
        ST_DONE
    } coh_state_e;
endpackage

// File: rtl/coh_range_chk.sv
module coh_range_chk #(
    parameter int AW    = 16,
    parameter int LEN_W = 6,
    parameter int BOFF  = 2
) (
    input  logic [AW-1:0]    addr,
    input  logic [LEN_W-1:0] len,
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    last,
    output logic             bad
);
    localparam int PADW = AW + 1 - LEN_W;

    logic [AW:0] span_bytes;
    logic [AW:0] span_end;
    logic        zero_len;
    logic        past_top;
    logic        overlap;

    always_comb begin
        span_bytes = {{PADW{1'b0}}, len} << BOFF;
        span_end   = {1'b0, addr} + span_bytes - {{AW{1'b0}}, 1'b1};
        zero_len   = (len == '0);
        past_top   = span_end[AW];
        overlap    = (addr <= last) && (span_end[AW-1:0] >= base);
        bad        = zero_len || past_top || overlap;
    end
endmodule

// File: rtl/coh_snoop_track.sv
module coh_snoop_track (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic need_ic,
    input  logic dc_ack,
    input  logic dc_dirty,
    input  logic ic_ack,
    output logic dc_pend,
    output logic ic_pend,
    output logic dirty,
    output logic wb_load
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dc_pend <= 1'b0;
            ic_pend <= 1'b0;
            dirty   <= 1'b0;
        end else if (start) begin
            dc_pend <= 1'b1;
            ic_pend <= need_ic;
            dirty   <= 1'b0;
        end else begin
            if (dc_pend && dc_ack) begin
                dc_pend <= 1'b0;
                dirty   <= dc_dirty;
            end
            if (ic_pend && ic_ack) begin
                ic_pend <= 1'b0;
            end
        end
    end

    assign wb_load = dc_pend && dc_ack && dc_dirty;

    // R5: a new line is never started while the previous one is still open
    p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (!dc_pend && !ic_pend));
endmodule

// File: rtl/coh_line_buf.sv
module coh_line_buf #(
    parameter int WORDS = 16,
    parameter int DW    = 32,
    parameter int OFF_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld,
    input  logic [WORDS*DW-1:0] ld_data,
    input  logic                wr,
    input  logic [OFF_W-1:0]    wr_idx,
    input  logic [DW-1:0]       wr_data,
    input  logic [OFF_W-1:0]    rd_idx,
    output logic [DW-1:0]       rd_data
);
    logic [DW-1:0] word_q [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[i] <= '0;
            end else if (wr && (wr_idx == OFF_W'(i))) begin
                word_q[i] <= wr_data;
            end else if (ld) begin
                word_q[i] <= ld_data[i*DW +: DW];
            end
        end
    end

    assign rd_data = word_q[rd_idx];
endmodule

// File: rtl/coh_dma_snoop.sv
module coh_dma_snoop
    import coh_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int LINE_BYTES = 64,
    parameter int LEN_W      = 6,
    localparam int WB        = DW / 8,
    localparam int BOFF      = $clog2(WB),
    localparam int WORDS     = LINE_BYTES / WB,
    localparam int OFF_W     = $clog2(WORDS),
    localparam int LOFF      = $clog2(LINE_BYTES),
    localparam int LINE_W    = AW - LOFF,
    localparam int WA_W      = AW - BOFF,
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        cfg_l2c_base,
    input  logic [AW-1:0]        cfg_l2c_last,
    input  logic                 cfg_rd_inval,
    input  logic                 dma_req_valid,
    output logic                 dma_req_ready,
    input  logic                 dma_req_write,
    input  logic [AW-1:0]        dma_req_addr,
    input  logic [LEN_W-1:0]     dma_req_len,
    output logic                 dma_wready,
    input  logic [DW-1:0]        dma_wdata,
    output logic                 dma_rvalid,
    output logic [DW-1:0]        dma_rdata,
    output logic                 dma_rsp_valid,
    output logic                 dma_rsp_err,
    output logic                 dc_snp_valid,
    output logic                 dc_snp_inv,
    output logic [LINE_W-1:0]    dc_snp_line,
    input  logic                 dc_snp_ack,
    input  logic                 dc_snp_dirty,
    input  logic [LINE_BITS-1:0] dc_snp_wb_data,
    output logic                 ic_inv_valid,
    output logic [LINE_W-1:0]    ic_inv_line,
    input  logic                 ic_inv_ack,
    output logic                 sram_en,
    output logic                 sram_we,
    output logic [WA_W-1:0]      sram_addr,
    output logic [DW-1:0]        sram_wdata,
    input  logic [DW-1:0]        sram_rdata
);
    coh_state_e state_q, state_d;

    logic              cur_write;
    logic              cur_rinv;
    logic [WA_W-1:0]   cur_wa;
    logic [LEN_W-1:0]  rem;
    logic [LINE_W-1:0] line_q;
    logic [OFF_W-1:0]  cnt;
    logic              rvalid_q;

    logic              req_bad;
    logic              accept;
    logic              snp_start;
    logic              dc_pend, ic_pend, line_dirty, wb_load;
    logic              snp_done;
    logic              last_beat, last_in_line, line_end;
    logic              merge_mode;
    logic              buf_wr;
    logic [DW-1:0]     buf_rd;

    coh_range_chk #(.AW(AW), .LEN_W(LEN_W), .BOFF(BOFF)) u_range (
        .addr (dma_req_addr),
        .len  (dma_req_len),
        .base (cfg_l2c_base),
        .last (cfg_l2c_last),
        .bad  (req_bad)
    );

    coh_snoop_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (snp_start),
        .need_ic  (accept ? dma_req_write : cur_write),
        .dc_ack   (dc_snp_ack),
        .dc_dirty (dc_snp_dirty),
        .ic_ack   (ic_inv_ack),
        .dc_pend  (dc_pend),
        .ic_pend  (ic_pend),
        .dirty    (line_dirty),
        .wb_load  (wb_load)
    );

    coh_line_buf #(.WORDS(WORDS), .DW(DW), .OFF_W(OFF_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (wb_load),
        .ld_data (dc_snp_wb_data),
        .wr      (buf_wr),
        .wr_idx  (cur_wa[OFF_W-1:0]),
        .wr_data (dma_wdata),
        .rd_idx  (cnt),
        .rd_data (buf_rd)
    );

    // ---------------- control decode ----------------
    always_comb begin
        accept       = (state_q == ST_IDLE) && dma_req_valid && !req_bad;
        snp_done     = (state_q == ST_SNOOP) && !dc_pend && !ic_pend;
        last_beat    = (rem == LEN_W'(1));
        last_in_line = &cur_wa[OFF_W-1:0];
        line_end     = last_beat || last_in_line;
        merge_mode   = cur_write && line_dirty;
        buf_wr       = (state_q == ST_XFER) && merge_mode;
        snp_start    = accept ||
                       ((state_q == ST_XFER) && line_end && !last_beat && !merge_mode) ||
                       ((state_q == ST_MERGE) && (&cnt) && (rem != '0));
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (dma_req_valid) begin
                    state_d = req_bad ? ST_REJECT : ST_SNOOP;
                end
            end
            ST_REJECT: state_d = ST_IDLE;
            ST_SNOOP: begin
                if (snp_done) begin
                    state_d = (line_dirty && !cur_write) ? ST_WBACK : ST_XFER;
                end
            end
            ST_WBACK: begin
                if (&cnt) state_d = ST_XFER;
            end
            ST_XFER: begin
                if (line_end) begin
                    if (merge_mode)     state_d = ST_MERGE;
                    else if (last_beat) state_d = ST_DONE;
                    else                state_d = ST_SNOOP;
                end
            end
            ST_MERGE: begin
                if (&cnt) state_d = (rem == '0) ? ST_DONE : ST_SNOOP;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_rinv  <= 1'b0;
            cur_wa    <= '0;
            rem       <= '0;
            line_q    <= '0;
            cnt       <= '0;
            rvalid_q  <= 1'b0;
        end else begin
            rvalid_q <= (state_q == ST_XFER) && !cur_write;
            if (accept) begin
                cur_write <= dma_req_write;
                cur_rinv  <= cfg_rd_inval;
                cur_wa    <= dma_req_addr[AW-1:BOFF];
                rem       <= dma_req_len;
            end
            if (state_q == ST_SNOOP) begin
                line_q <= cur_wa[WA_W-1:OFF_W];
            end
            if (state_q == ST_XFER) begin
                cur_wa <= cur_wa + WA_W'(1);
                rem    <= rem - LEN_W'(1);
            end
            if ((state_q == ST_WBACK) || (state_q == ST_MERGE)) begin
                cnt <= cnt + OFF_W'(1);
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        dma_req_ready = (state_q == ST_IDLE);
        dma_wready    = (state_q == ST_XFER) && cur_write;
        dma_rvalid    = rvalid_q;
        dma_rdata     = sram_rdata;
        dma_rsp_valid = (state_q == ST_REJECT) || (state_q == ST_DONE);
        dma_rsp_err   = (state_q == ST_REJECT);
        dc_snp_valid  = dc_pend;
        dc_snp_inv    = cur_write || cur_rinv;
        dc_snp_line   = cur_wa[WA_W-1:OFF_W];
        ic_inv_valid  = ic_pend;
        ic_inv_line   = cur_wa[WA_W-1:OFF_W];
        sram_en       = 1'b0;
        sram_we       = 1'b0;
        sram_addr     = cur_wa;
        sram_wdata    = dma_wdata;
        unique case (state_q)
            ST_WBACK, ST_MERGE: begin
                sram_en    = 1'b1;
                sram_we    = 1'b1;
                sram_addr  = {line_q, cnt};
                sram_wdata = buf_rd;
            end
            ST_XFER: begin
                sram_en = !merge_mode;
                sram_we = cur_write;
            end
            default: begin
                sram_en = 1'b0;
            end
        endcase
    end

    // ---------------- assertions ----------------
    p_reject_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rsp_err |-> (!sram_en && !dc_snp_valid && !ic_inv_valid && !dma_wready));

    // R3: a keep-valid (read) snoop is never paired with an instruction invalidate
    p_read_no_ic_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_snp_valid && !dc_snp_inv) |-> !ic_inv_valid);

    p_snoop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_snp_valid && !dc_snp_ack) |=> (dc_snp_valid && $stable(dc_snp_line)));

    p_no_data_in_snoop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_snp_valid || ic_inv_valid) |-> (!dma_wready && !sram_en));

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rsp_valid |=> !dma_rsp_valid);
endmodule

// File: tb/tb_coh_dma_snoop.sv
module tb_coh_dma_snoop;
    localparam int AW = 16, DW = 32, LEN_W = 6, LINE_W = 10, WA_W = 14, WORDS = 16;
    localparam int LB = 512;
    localparam int NWORDS = 1 << WA_W;
    localparam int NLINES = 1 << LINE_W;
    localparam logic [15:0] CFG_BASE = 16'hC000;
    localparam logic [15:0] CFG_LAST = 16'hFFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [AW-1:0] cfg_l2c_base = CFG_BASE, cfg_l2c_last = CFG_LAST;
    logic cfg_rd_inval = 1'b0;
    logic dma_req_valid = 1'b0, dma_req_write = 1'b0;
    logic [AW-1:0] dma_req_addr = '0;
    logic [LEN_W-1:0] dma_req_len = '0;
    logic dma_req_ready, dma_wready, dma_rvalid, dma_rsp_valid, dma_rsp_err;
    logic [DW-1:0] dma_wdata = '0, dma_rdata;
    logic dc_snp_valid, dc_snp_inv, ic_inv_valid;
    logic [LINE_W-1:0] dc_snp_line, ic_inv_line;
    logic dc_snp_ack = 1'b0, dc_snp_dirty = 1'b0, ic_inv_ack = 1'b0;
    logic [LB-1:0] dc_snp_wb_data = '0;
    logic sram_en, sram_we;
    logic [WA_W-1:0] sram_addr;
    logic [DW-1:0] sram_wdata, sram_rdata;

    coh_dma_snoop dut (.*);

    int errors = 0, checks = 0;

    // ---------------- models ----------------
    logic [31:0] mem     [NWORDS];
    logic [31:0] ref_mem [NWORDS];
    bit dc_v [NLINES];
    bit dc_d [NLINES];
    logic [LB-1:0] dc_dat [NLINES];
    bit ic_v [NLINES];
    int sram_acts = 0;

    always @(posedge clk) begin
        if (sram_en) begin
            sram_acts <= sram_acts + 1;
            if (sram_we) mem[sram_addr] <= sram_wdata;
            else         sram_rdata <= mem[sram_addr];
        end
    end

    int dc_dly = 0, ic_dly = 0;
    int snp_n = 0, ic_n = 0;
    int snp_ln [64];
    bit snp_iv [64];
    int ic_ln [64];
    int overlap_viol = 0;

    always @(negedge clk) begin
        if (dc_snp_ack) begin
            dc_snp_ack = 1'b0;
            dc_snp_dirty = 1'b0;
            dc_dly = $urandom % 4;
        end else if (dc_snp_valid) begin
            if (dc_dly == 0) begin
                int ln;
                ln = int'(dc_snp_line);
                dc_snp_ack = 1'b1;
                dc_snp_dirty = dc_v[ln] && dc_d[ln];
                dc_snp_wb_data = dc_dat[ln];
                dc_d[ln] = 1'b0;
                if (dc_snp_inv) dc_v[ln] = 1'b0;
                if (snp_n < 64) begin
                    snp_ln[snp_n] = ln;
                    snp_iv[snp_n] = dc_snp_inv;
                end
                snp_n++;
            end else dc_dly--;
        end
    end

    always @(negedge clk) begin
        if (ic_inv_ack) begin
            ic_inv_ack = 1'b0;
            ic_dly = $urandom % 5;
        end else if (ic_inv_valid) begin
            if (ic_dly == 0) begin
                ic_inv_ack = 1'b1;
                ic_v[int'(ic_inv_line)] = 1'b0;
                if (ic_n < 64) ic_ln[ic_n] = int'(ic_inv_line);
                ic_n++;
            end else ic_dly--;
        end
    end

    // R5 monitor: data movement while a cache command is outstanding
    always @(negedge clk) begin
        if (rst_n && (dc_snp_valid || ic_inv_valid) && (dma_wready || sram_en))
            overlap_viol++;
    end

    logic [31:0] wbuf [64];
    logic [31:0] rcap [64];
    int wbeat = 0, rcnt = 0;
    always @(negedge clk) begin
        if (dma_wready) begin
            dma_wdata = wbuf[wbeat % 64];
            wbeat++;
        end
        if (dma_rvalid) begin
            if (rcnt < 64) rcap[rcnt] = dma_rdata;
            rcnt++;
        end
    end

    // ---------------- bench functions ----------------
    function automatic bit range_bad(int addr, int len);
        int e;
        e = addr + len * 4 - 1;
        return (len == 0) || (e > 16'hFFFF) ||
               ((addr <= int'(CFG_LAST)) && (e >= int'(CFG_BASE)));
    endfunction

    function automatic logic [LB-1:0] rand_line();
        logic [LB-1:0] v;
        for (int i = 0; i < WORDS; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic make_dirty(int ln);
        dc_v[ln] = 1'b1;
        dc_d[ln] = 1'b1;
        dc_dat[ln] = rand_line();
        ic_v[ln] = 1'b1;
    endtask

    task automatic do_xfer(bit wr, int addr, int len, bit rinv);
        bit bad;
        int first_l, last_l, nl, acts0, mism;
        bit pre_v [64];
        logic [31:0] exp_r [64];
        bad = range_bad(addr, len);
        first_l = addr >> 6;
        last_l = (addr + len * 4 - 1) >> 6;
        nl = bad ? 0 : (last_l - first_l + 1);
        for (int i = 0; i < 64; i++) wbuf[i] = $urandom;
        if (!bad) begin
            for (int l = 0; l < nl; l++) begin
                int ln;
                ln = first_l + l;
                pre_v[l] = dc_v[ln];
                if (dc_v[ln] && dc_d[ln])
                    for (int w = 0; w < WORDS; w++) ref_mem[ln*16 + w] = dc_dat[ln][w*32 +: 32];
            end
            for (int w = 0; w < len; w++) begin
                int wa;
                wa = (addr >> 2) + w;
                if (wr) ref_mem[wa] = wbuf[w];
                else    exp_r[w] = ref_mem[wa];
            end
        end
        snp_n = 0; ic_n = 0; wbeat = 0; rcnt = 0;
        acts0 = sram_acts;
        @(negedge clk);
        dma_req_valid = 1'b1;
        dma_req_write = wr;
        dma_req_addr = 16'(addr);
        dma_req_len = 6'(len);
        cfg_rd_inval = rinv;
        @(posedge clk);
        @(negedge clk);
        dma_req_valid = 1'b0;
        while (!dma_rsp_valid) @(negedge clk);
        chk(dma_rsp_err == bad, bad ? "R1" : "R10", "response error flag", dma_rsp_err, bad);
        @(negedge clk);
        chk(!dma_rsp_valid, "R10", "response is one cycle", dma_rsp_valid, 0);
        if (bad) begin
            chk(snp_n == 0 && ic_n == 0, "R1", "no cache command on refusal", snp_n + ic_n, 0);
            chk(sram_acts == acts0 && wbeat == 0, "R1", "no SRAM/DMA data on refusal",
                sram_acts - acts0 + wbeat, 0);
        end else begin
            chk(snp_n == nl, "R4", "snoop count", snp_n, nl);
            mism = 0;
            for (int l = 0; l < nl && l < 64; l++)
                if (snp_ln[l] != first_l + l || snp_iv[l] != (wr || rinv)) mism++;
            chk(mism == 0, wr ? "R2" : "R3", "snoop lines ascending / inv flag", mism, 0);
            mism = 0;
            if (wr) for (int l = 0; l < nl && l < 64; l++) if (ic_ln[l] != first_l + l) mism++;
            chk(ic_n == (wr ? nl : 0) && mism == 0, wr ? "R2" : "R3",
                "instruction invalidates", ic_n, wr ? nl : 0);
            mism = 0;
            for (int l = 0; l < nl; l++)
                for (int w = 0; w < WORDS; w++)
                    if (mem[(first_l + l)*16 + w] != ref_mem[(first_l + l)*16 + w]) mism++;
            chk(mism == 0, wr ? "R6" : "R7", "SRAM line contents", mism, 0);
            if (wr) begin
                chk(wbeat == len, "R9", "write beats", wbeat, len);
            end else begin
                chk(rcnt == len, "R9", "read beats", rcnt, len);
                mism = 0;
                for (int w = 0; w < len && w < 64; w++) if (rcap[w] !== exp_r[w]) mism++;
                chk(mism == 0, "R7", "read data", mism, 0);
            end
            mism = 0;
            for (int l = 0; l < nl; l++) begin
                int ln;
                ln = first_l + l;
                if (dc_d[ln]) mism++;
                if (wr && (dc_v[ln] || ic_v[ln])) mism++;
                if (!wr && dc_v[ln] != (pre_v[l] && !rinv)) mism++;
            end
            chk(mism == 0, wr ? "R2" : "R3", "cache line state after snoop", mism, 0);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int mism;
        void'($urandom(32'd4242));
        for (int i = 0; i < NWORDS; i++) begin
            mem[i] = 32'(i) ^ 32'h5A5A0000;
            ref_mem[i] = 32'(i) ^ 32'h5A5A0000;
        end
        for (int i = 0; i < NLINES; i++) begin
            dc_v[i] = 1'b0; dc_d[i] = 1'b0; dc_dat[i] = '0; ic_v[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dma_req_ready && !dc_snp_valid && !ic_inv_valid && !sram_en && !dma_rsp_valid,
            "R11", "reset state", {dma_req_ready, dc_snp_valid, ic_inv_valid, sram_en, dma_rsp_valid}, 5'b10000);

        // R8: clean write
        ic_v[4] = 1'b1;
        do_xfer(1'b1, 16'h0100, 4, 1'b0);
        // R6: partial write into a dirty line
        make_dirty(5);
        do_xfer(1'b1, 16'h0148, 3, 1'b0);
        // R7: dirty read, keep valid then invalidate
        make_dirty(6);
        do_xfer(1'b0, 16'h0184, 5, 1'b0);
        make_dirty(6);
        do_xfer(1'b0, 16'h0180, 16, 1'b1);
        // R4: burst over three lines with middle line dirty
        make_dirty(8);
        do_xfer(1'b1, 16'h01F8, 20, 1'b0);
        make_dirty(8);
        do_xfer(1'b0, 16'h01F8, 20, 1'b0);
        // R1: boundaries of the cache window
        do_xfer(1'b1, 16'hBFF8, 2, 1'b0);
        do_xfer(1'b1, 16'hBFFC, 2, 1'b0);
        do_xfer(1'b0, 16'hC010, 1, 1'b0);
        do_xfer(1'b1, 16'h0200, 0, 1'b0);

        // random traffic
        for (int n = 0; n < 120; n++) begin
            int a, l;
            for (int k = 0; k < 2; k++) make_dirty($urandom % 128);
            if ($urandom % 8 == 0) a = 16'hBF00 + (($urandom % 64) * 4);
            else                   a = ($urandom % 16'h2000) & ~3;
            l = 1 + ($urandom % 32);
            do_xfer(1'($urandom), a, l, 1'($urandom));
        end

        chk(overlap_viol == 0, "R5", "data moved while snoop outstanding", overlap_viol, 0);
        mism = 0;
        for (int i = 0; i < NWORDS; i++) if (mem[i] !== ref_mem[i]) mism++;
        chk(mism == 0, "R8", "whole SRAM matches reference", mism, 0);
        finish_run();
    end
endmodule